// File: doc/BRIEF.md
# Transmit Completion Ring Writer

This block sits on the device side of a transmit path. It turns completion requests into 8-byte ring entries and writes them into a host completion ring whose depth is a power of two. A request carries a completion kind, an 11-bit queue number and a 16-bit value. For packet-type kinds the value is the packet's completion tag. For a descriptor completion it is the ring head, meaning the index of the last fetched descriptor plus one. Entries go to consecutive ring slots, one write per accepted request, and the outputs are registered one cycle after acceptance.

The consumer finds new entries by looking at an ownership bit in each entry, with no index register to read. It fills the ring with 0 before the device starts. The writer stamps 1 into every entry on the first pass over the ring and inverts that stamp each time its write pointer wraps.

Packets that take the slow miss path first get a miss completion and later a reinjection completion carrying the same tag. The block keeps a small set of tags with an outstanding miss. It writes a reinjection only when its tag is in that set, and that write clears the tag. Requests the block refuses raise a one-cycle error pulse in place of a write.

Top module: `cq_compl_writer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, wr_en_o and err_o are low.
- R2: Entry layout: bits [10:0] hold the queue number, bits [13:11] the kind code, bit 14 is 0, bit 15 is the ownership stamp, bits [31:16] hold the tag or head value, and bits [63:32] are 0.
- R3: The accepted kind codes are 1 (miss), 2 (packet), 3 (reinjection) and 4 (descriptor). Codes 0, 5, 6 and 7 are refused: err_o pulses and nothing is written.
- R4: An accepted request is written one cycle after acceptance. Written entries go to ring addresses 0, 1, 2 and so on, wrapping from DEPTH-1 back to 0. Refused requests do not move the address.
- R5: The ownership stamp is 1 on the first pass over the ring and inverts after each wrap of the address.
- R6: A miss completion for a tag that is not yet outstanding is written and records the tag. A later reinjection with that tag is written and removes the tag.
- R7: A reinjection whose tag has no outstanding miss is refused with an err_o pulse and no write.
- R8: A miss completion is refused with an err_o pulse when its tag is already outstanding or when MISS_SLOTS tags (8 by default) are outstanding.
- R9: Packet and descriptor completions are always written, in whatever order they arrive, whatever the set of outstanding misses.
- R10: wr_en_o and err_o are never high in the same cycle.
- R11: req_ready_o is high in every cycle from the first clock edge after reset, so one request can be accepted per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_kind_i | input | 3 | Completion kind code |
| req_qid_i | input | 11 | Transmit queue number |
| req_val_i | input | 16 | Completion tag or ring head value |
| wr_en_o | output | 1 | Ring entry write strobe |
| wr_addr_o | output | $clog2(DEPTH) | Ring slot index |
| wr_data_o | output | 64 | Formatted ring entry |
| err_o | output | 1 | One-cycle pulse for a refused request |

## Verification
The hardest situation to reach is a full set of outstanding miss tags in the same stretch as duplicate misses, unmatched reinjections and ring wraps. Uniform random traffic seldom leaves eight misses open at the same time. The directed part of the stimulus therefore opens eight distinct miss tags and then offers a ninth tag, a duplicate tag and an unknown reinjection. It then frees one slot and checks that the slot can be used again. The random part draws tags from a pool of twelve and weights the miss and reinjection kinds heavily, so the set often fills and drains while the 16-entry ring wraps many times.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int QID_W = 11;
  localparam int VAL_W = 16;

  localparam logic [2:0] CK_MISS  = 3'd1;
  localparam logic [2:0] CK_PKT   = 3'd2;
  localparam logic [2:0] CK_REINJ = 3'd3;
  localparam logic [2:0] CK_DESC  = 3'd4;

  typedef struct packed {
    logic [31:0]      rsvd_hi;
    logic [VAL_W-1:0] val;
    logic             gen;
    logic             rsvd_lo;
    logic [2:0]       kind;
    logic [QID_W-1:0] qid;
  } cq_entry_t;
endpackage

// File: rtl/cq_entry_fmt.sv
module cq_entry_fmt
  import cq_pkg::*;
(
  input  logic [2:0]       kind_i,
  input  logic [QID_W-1:0] qid_i,
  input  logic [VAL_W-1:0] val_i,
  input  logic             gen_i,
  output logic [63:0]      data_o
);
  cq_entry_t ent;

  always_comb begin
    ent         = '0;
    ent.qid     = qid_i;
    ent.kind    = kind_i;
    ent.gen     = gen_i;
    ent.val     = val_i;
  end

  assign data_o = ent;
endmodule

// File: rtl/cq_ring_ptr.sv
module cq_ring_ptr #(
  parameter int DEPTH = 16
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   adv_i,
  output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] ptr_o,
  output logic                                   gen_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q;
  logic          gen_q;
  logic          wrap;

  assign wrap = adv_i && (ptr_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      gen_q <= 1'b1;  // ring is preset to 0 by the consumer
    end else if (adv_i) begin
      ptr_q <= wrap ? '0 : ptr_q + 1'b1;
      if (wrap) gen_q <= ~gen_q;
    end
  end

  assign ptr_o = ptr_q;
  assign gen_o = gen_q;

  a_r4_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> ptr_o == (($past(ptr_o) == LAST) ? '0 : $past(ptr_o) + 1'b1));
  a_r4_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_o));
  a_r5_gen_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && ptr_o == LAST) |=> gen_o != $past(gen_o));
  a_r5_gen_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(adv_i && ptr_o == LAST) |=> $stable(gen_o));
endmodule

// File: rtl/cq_miss_table.sv
module cq_miss_table #(
  parameter int N     = 8,
  parameter int TAG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o,
  output logic             full_o,
  input  logic             ins_i,
  input  logic             rel_i
);
  logic [N-1:0]     vld_q;
  logic [N-1:0]     hit_v;
  logic [N-1:0]     free_oh;
  logic [TAG_W-1:0] tag_q [N];

  // lowest clear bit of vld_q
  assign free_oh = ~vld_q & (vld_q + 1'b1);
  assign full_o  = &vld_q;
  assign hit_o   = |hit_v;

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign hit_v[g] = vld_q[g] && (tag_q[g] == tag_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    tag_q[g] <= '0;
      else if (ins_i && free_oh[g])   tag_q[g] <= tag_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     vld_q <= '0;
    else if (ins_i)  vld_q <= vld_q | free_oh;
    else if (rel_i)  vld_q <= vld_q & ~hit_v;
  end

  a_r8_unique_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_v));
  a_r8_ins_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i |-> !full_o && !hit_o);
  a_r6_ins_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i |=> $countones(vld_q) == $countones($past(vld_q)) + 1);
  a_r6_rel_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_i && !ins_i) |=> $countones(vld_q) + 1 == $countones($past(vld_q)));
endmodule

// File: rtl/cq_compl_writer.sv
module cq_compl_writer
  import cq_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int MISS_SLOTS = 8,
  localparam int AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [2:0]       req_kind_i,
  input  logic [10:0]      req_qid_i,
  input  logic [15:0]      req_val_i,
  output logic             wr_en_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [63:0]      wr_data_o,
  output logic             err_o
);
  logic          rdy_q;
  logic          acc, is_pkt, is_desc, is_miss, is_reinj;
  logic          hit, full, ok, do_wr, do_rej;
  logic [AW-1:0] ptr;
  logic          gen;
  logic [63:0]   ent;

  logic          wr_q, err_q;
  logic [AW-1:0] addr_q;
  logic [63:0]   data_q;

  assign acc      = req_valid_i && rdy_q;
  assign is_pkt   = req_kind_i == CK_PKT;
  assign is_desc  = req_kind_i == CK_DESC;
  assign is_miss  = req_kind_i == CK_MISS;
  assign is_reinj = req_kind_i == CK_REINJ;

  assign ok = is_pkt || is_desc
           || (is_miss && !full && !hit)
           || (is_reinj && hit);
  assign do_wr  = acc && ok;
  assign do_rej = acc && !ok;

  cq_miss_table #(.N(MISS_SLOTS), .TAG_W(VAL_W)) i_miss (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tag_i  (req_val_i),
    .hit_o  (hit),
    .full_o (full),
    .ins_i  (do_wr && is_miss),
    .rel_i  (do_wr && is_reinj)
  );

  cq_ring_ptr #(.DEPTH(DEPTH)) i_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (do_wr),
    .ptr_o  (ptr),
    .gen_o  (gen)
  );

  cq_entry_fmt i_fmt (
    .kind_i (req_kind_i),
    .qid_i  (req_qid_i),
    .val_i  (req_val_i),
    .gen_i  (gen),
    .data_o (ent)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q  <= 1'b0;
      wr_q   <= 1'b0;
      err_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      rdy_q <= 1'b1;
      wr_q  <= do_wr;
      err_q <= do_rej;
      if (do_wr) begin
        addr_q <= ptr;
        data_q <= ent;
      end
    end
  end

  assign req_ready_o = rdy_q;
  assign wr_en_o     = wr_q;
  assign err_o       = err_q;
  assign wr_addr_o   = addr_q;
  assign wr_data_o   = data_q;

  a_r10_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_o && err_o));
  a_r2_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_data_o[63:32] == '0) && !wr_data_o[14]);
  a_r7_unmatched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && is_reinj && !hit) |=> err_o && !wr_en_o);
  a_r9_always_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && (is_pkt || is_desc)) |=> wr_en_o);
  a_r3_bad_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !(is_pkt || is_desc || is_miss || is_reinj)) |=> err_o);
  a_r11_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> req_ready_o);
endmodule

// File: tb/test_cq_compl_writer.sv
`timescale 1ns/1ps
module test_cq_compl_writer;
  localparam int DEPTH = 16;
  localparam int SLOTS = 8;
  localparam int AW    = $clog2(DEPTH);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_kind = '0;
  logic [10:0] req_qid = '0;
  logic [15:0] req_val = '0;
  logic        wr_en, err;
  logic [AW-1:0] wr_addr;
  logic [63:0] wr_data;

  always #2.5 clk = ~clk;

  cq_compl_writer #(.DEPTH(DEPTH), .MISS_SLOTS(SLOTS)) i_cq_compl_writer (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_kind_i(req_kind), .req_qid_i(req_qid), .req_val_i(req_val),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .err_o(err)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  int          m_ptr = 0;
  logic        m_gen = 1'b1;
  bit          m_v [SLOTS];
  logic [15:0] m_t [SLOTS];

  // pending expectation
  logic        e_wr = 0, e_err = 0;
  logic [AW-1:0] e_addr = '0;
  logic [63:0] e_data = '0;
  string       e_lbl = "R1";

  task automatic chk(input string r, input logic [63:0] a, input logic [63:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", r, a, e);
    end
  endtask

  function automatic int m_find(input logic [15:0] t);
    for (int i = 0; i < SLOTS; i++) if (m_v[i] && m_t[i] == t) return i;
    return -1;
  endfunction

  function automatic int m_cnt();
    int c = 0;
    for (int i = 0; i < SLOTS; i++) c += int'(m_v[i]);
    return c;
  endfunction

  function automatic logic [63:0] mk_ent(input logic [2:0] k, input logic [10:0] q,
                                         input logic [15:0] t, input logic g);
    return {32'h0, t, g, 1'b0, k, q};
  endfunction

  task automatic predict(input logic v, input logic [2:0] k, input logic [10:0] q,
                         input logic [15:0] t);
    bit ok;
    int idx;
    e_wr = 0; e_err = 0;
    if (!v) begin e_lbl = "R4 idle"; return; end
    idx = m_find(t);
    case (k)
      3'd2, 3'd4: begin ok = 1; e_lbl = "R9"; end
      3'd1: begin ok = (idx < 0) && (m_cnt() < SLOTS); e_lbl = ok ? "R6 miss" : "R8"; end
      3'd3: begin ok = (idx >= 0); e_lbl = ok ? "R6 reinj" : "R7"; end
      default: begin ok = 0; e_lbl = "R3"; end
    endcase
    if (ok) begin
      e_wr   = 1;
      e_addr = AW'(m_ptr);
      e_data = mk_ent(k, q, t, m_gen);
      if (k == 3'd1) begin
        for (int i = 0; i < SLOTS; i++)
          if (!m_v[i]) begin m_v[i] = 1; m_t[i] = t; break; end
      end
      if (k == 3'd3) m_v[idx] = 0;
      if (m_ptr == DEPTH - 1) begin m_ptr = 0; m_gen = ~m_gen; end
      else m_ptr++;
    end else begin
      e_err = 1;
    end
  endtask

  task automatic check_out();
    chk({e_lbl, " wr_en"}, 64'(wr_en), 64'(e_wr));
    chk({e_lbl, " err"}, 64'(err), 64'(e_err));
    chk("R10 excl", 64'(wr_en && err), 64'h0);
    chk("R11 ready", 64'(req_ready), 64'h1);
    if (e_wr && wr_en) begin
      chk("R4 addr", 64'(wr_addr), 64'(e_addr));
      chk("R5 gen", 64'(wr_data[15]), 64'(e_data[15]));
      chk("R3 kind field", 64'(wr_data[13:11]), 64'(e_data[13:11]));
      chk("R2 entry", wr_data, e_data);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] k, input logic [10:0] q,
                      input logic [15:0] t);
    @(negedge clk);
    check_out();
    req_valid = v; req_kind = k; req_qid = q; req_val = t;
    predict(v, k, q, t);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < SLOTS; i++) begin m_v[i] = 0; m_t[i] = '0; end
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    chk("R1 reset wr_en", 64'(wr_en), 64'h0);
    chk("R1 reset err", 64'(err), 64'h0);
    rst_n = 1'b1;
    step(0, 3'd0, 11'd0, 16'd0);  // R1: first cycle after reset is quiet
    // R9: packet and descriptor, out of tag order
    step(1, 3'd2, 11'd5, 16'h0042);
    step(1, 3'd4, 11'h7FF, 16'hFFFF);
    step(1, 3'd2, 11'd1, 16'h0001);
    // R3: illegal codes
    for (int k = 0; k < 8; k++)
      if (k == 0 || k > 4) step(1, 3'(k), 11'd9, 16'h1111);
    // R6/R8: fill the miss set
    for (int i = 0; i < SLOTS; i++) step(1, 3'd1, 11'(i), 16'(100 + i));
    step(1, 3'd1, 11'd3, 16'd200);   // R8 full
    step(1, 3'd1, 11'd3, 16'd104);   // R8 duplicate
    step(1, 3'd3, 11'd3, 16'd200);   // R7 unknown
    step(1, 3'd3, 11'd3, 16'd103);   // R6 release
    step(1, 3'd3, 11'd3, 16'd103);   // R7 already released
    step(1, 3'd1, 11'd3, 16'd108);   // R6 slot reuse
    step(1, 3'd2, 11'd2, 16'd105);   // R9 packet while tag outstanding
    for (int i = 7; i >= 0; i--) step(1, 3'd3, 11'd0, 16'(100 + i + (i == 3 ? 5 : 0)));
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom % 10;
      logic [2:0] k;
      if (r < 3) k = 3'd1;
      else if (r < 6) k = 3'd3;
      else if (r < 8) k = ($urandom % 2) ? 3'd2 : 3'd4;
      else k = 3'($urandom % 8);
      step(($urandom % 5) != 0, k, 11'($urandom), 16'($urandom % 12));
    end
    step(0, 3'd0, 11'd0, 16'd0);
    step(0, 3'd0, 11'd0, 16'd0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule